// File: doc/BRIEF.md
# Dual-Thread Branch Direction and Target Predictor

This block predicts the direction and target of conditional branches for an in-order core that runs two hardware threads. A fetch lookup carries a thread number and a program counter; one cycle later the block answers with a hit flag, a taken/not-taken guess and a target address. Direction comes from a two-level adaptive scheme. Each thread keeps its own 12-bit outcome history. That history is combined with low PC bits to pick one 2-bit saturating counter out of a single 8192-entry counter table, and both threads share that table. Targets come from a 128-entry target cache, organised as 32 sets of 4 ways.

Each target-cache entry also carries a static tag. A newly installed branch is tagged "always taken" or "never taken", matching its first resolved outcome. While the tag is set, it decides the prediction and the counter is ignored. The first outcome that contradicts the tag turns the entry dynamic for good. Unconditional jumps are left out of the predictor completely.

Lookups use a valid/ready request and a valid/ready response with a single response register. A request is accepted only when that register is empty or is being drained in the same cycle. While the response is held (valid high, ready low), it stays frozen and no new lookup is accepted. The resolve-time update port has a ready that is always high, so an update is taken in every cycle in which its valid is high.

Top module: `dual_thread_bpred`

## Requirements
- R1: After reset, the target cache holds no entries, every thread history is zero, every counter holds 01 (weakly not-taken), `rsp_valid` is 0, and `lk_ready` is 1.
- R2: A lookup is accepted in a cycle with `lk_valid` and `lk_ready` both high. Its response appears with `rsp_valid` high after that clock edge. `lk_ready` is 1 exactly when `rsp_valid` is 0 or `rsp_ready` is 1. While `rsp_valid` is high and `rsp_ready` is low, all response fields hold their values.
- R3: A lookup that finds no matching entry in the target cache returns `rsp_hit`=0, `rsp_taken`=0 and `rsp_target`=0.
- R4: A conditional update (`upd_kind`=0) whose PC misses in the target cache installs an entry. The entry stores `upd_target` and is tagged always-taken if `upd_taken`=1, or never-taken otherwise. The set is `pc[6:2]` and the tag is `pc[31:7]`.
- R5: A lookup that hits a tagged entry predicts taken for always-taken and not-taken for never-taken, whatever the counter value.
- R6: A conditional update that hits a tagged entry with the opposite outcome makes the entry dynamic. A hit on a dynamic entry predicts from bit 1 of the selected counter. The stored target is rewritten only by taken updates that hit.
- R7: The counter index is `{1'b0, hist[tid]} ^ pc[14:2]`. A conditional update steps the counter at the index formed with the thread's history before the update (saturating, +1 if taken, -1 if not). It then shifts the outcome into bit 0 of that thread's history. The other thread's history is untouched, and the counter table is shared by both threads.
- R8: An update with `upd_kind`=1 (unconditional jump) changes no target-cache entry, no counter and no history.
- R9: When a lookup and an update are accepted in the same cycle, the lookup response reflects the state before the update.
- R10: An install goes to the lowest-numbered empty way of the set. If the set is full, it goes to the way chosen by a 3-bit tree pseudo-LRU, which every conditional update that hits or installs in the set refreshes. Lookups do not refresh it.
- R11: `upd_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high |
| lk_tid | input | 1 | Thread number of the lookup |
| lk_pc | input | 32 | Branch PC to look up |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Target cache hit |
| rsp_taken | output | 1 | Predicted direction |
| rsp_target | output | 32 | Predicted target (0 on miss) |
| upd_valid | input | 1 | Resolved branch valid |
| upd_ready | output | 1 | Always 1 |
| upd_tid | input | 1 | Thread of the resolved branch |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_kind | input | 1 | 0 = conditional, 1 = unconditional jump |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target |

## Verification
The assertions assume that `lk_valid` and the lookup fields stay steady whenever they are sampled, and that the update fields are defined whenever `upd_valid` is high. The bench drives every input on the falling edge from tasks, so each value is fixed across the rising edge that samples it. The bench also keeps `upd_tid` and `lk_tid` within the two implemented threads. Back-pressure is exercised by holding `rsp_ready` low while a second request waits, and the shared counter table is observed through one thread's lookup after the other thread has trained it.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef enum logic [1:0] {
    BMODE_DYN    = 2'd0,
    BMODE_ALWAYS = 2'd1,
    BMODE_NEVER  = 2'd2
  } bmode_e;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

endpackage

// File: rtl/bpred_history.sv
module bpred_history #(
  parameter int THREADS = 2,
  parameter int HIST_W  = 12,
  parameter int TID_W   = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             shift_en,
  input  logic [TID_W-1:0]                 shift_tid,
  input  logic                             shift_bit,
  output logic [THREADS-1:0][HIST_W-1:0]   hist
);

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n)
        hist[t] <= '0;
      else if (shift_en && (shift_tid == TID_W'(t)))
        hist[t] <= {hist[t][HIST_W-2:0], shift_bit};
    end
  end

endmodule

// File: rtl/bpred_pht.sv
module bpred_pht
  import bpred_pkg::*;
#(
  parameter int IDX_W = 13,
  parameter int CPW   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int SLOT_W = $clog2(CPW);
  localparam int ROW_W  = IDX_W - SLOT_W;
  localparam int ROWS   = 1 << ROW_W;

  logic [2*CPW-1:0] rows [ROWS];

  logic [ROW_W-1:0]  rd_row, wr_row;
  logic [SLOT_W:0]   rd_bit, wr_bit;
  logic [1:0]        wr_old;

  assign rd_row = rd_idx[IDX_W-1:SLOT_W];
  assign rd_bit = {rd_idx[SLOT_W-1:0], 1'b0};
  assign wr_row = wr_idx[IDX_W-1:SLOT_W];
  assign wr_bit = {wr_idx[SLOT_W-1:0], 1'b0};

  assign rd_ctr = rows[rd_row][rd_bit +: 2];
  assign wr_old = rows[wr_row][wr_bit +: 2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) rows[r] <= {CPW{2'b01}};
    end else if (wr_en) begin
      rows[wr_row][wr_bit +: 2] <= ctr_step(wr_old, wr_taken);
    end
  end

endmodule

// File: rtl/bpred_btb.sv
module bpred_btb
  import bpred_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int SETS = 32,
  parameter int WAYS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output bmode_e          lk_mode,
  output logic [PC_W-1:0] lk_target,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = PC_W - SET_W - 2;

  logic              vld_q  [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [PC_W-1:0]   tgt_q  [SETS][WAYS];
  bmode_e            mode_q [SETS][WAYS];
  logic [WAYS-2:0]   plru_q [SETS];

  function automatic logic [WAY_W-1:0] plru_pick(input logic [WAYS-2:0] t);
    int node = 0;
    logic [WAY_W-1:0] w = '0;
    for (int l = 0; l < WAY_W; l++) begin
      w    = (w << 1) | WAY_W'(t[node]);
      node = 2 * node + 1 + (t[node] ? 1 : 0);
    end
    return w;
  endfunction

  function automatic logic [WAYS-2:0] plru_touch(input logic [WAYS-2:0] t,
                                                 input logic [WAY_W-1:0] w);
    int node = 0;
    logic [WAYS-2:0] r = t;
    for (int l = 0; l < WAY_W; l++) begin
      r[node] = ~w[WAY_W-1-l];
      node    = 2 * node + 1 + (w[WAY_W-1-l] ? 1 : 0);
    end
    return r;
  endfunction

  // lookup side
  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  assign lk_set = lk_pc[SET_W+1:2];
  assign lk_tag = lk_pc[PC_W-1:SET_W+2];

  always_comb begin
    lk_hit    = 1'b0;
    lk_mode   = BMODE_DYN;
    lk_target = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
        lk_hit    = 1'b1;
        lk_mode   = mode_q[lk_set][w];
        lk_target = tgt_q[lk_set][w];
      end
    end
  end

  // update side
  logic [SET_W-1:0] u_set;
  logic [TAG_W-1:0] u_tag;
  logic             u_hit, u_free;
  logic [WAY_W-1:0] u_hit_way, u_free_way, u_way;
  bmode_e           u_mode;

  assign u_set = upd_pc[SET_W+1:2];
  assign u_tag = upd_pc[PC_W-1:SET_W+2];

  always_comb begin
    u_hit      = 1'b0;
    u_hit_way  = '0;
    u_free     = 1'b0;
    u_free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[u_set][w] && tag_q[u_set][w] == u_tag) begin
        u_hit     = 1'b1;
        u_hit_way = WAY_W'(w);
      end
      if (!vld_q[u_set][w]) begin
        u_free     = 1'b1;
        u_free_way = WAY_W'(w);
      end
    end
    if (u_hit)       u_way = u_hit_way;
    else if (u_free) u_way = u_free_way;
    else             u_way = plru_pick(plru_q[u_set]);
    u_mode = mode_q[u_set][u_way];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        plru_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w]  <= 1'b0;
          tag_q[s][w]  <= '0;
          tgt_q[s][w]  <= '0;
          mode_q[s][w] <= BMODE_DYN;
        end
      end
    end else if (upd_en) begin
      plru_q[u_set] <= plru_touch(plru_q[u_set], u_way);
      if (u_hit) begin
        if ((u_mode == BMODE_ALWAYS && !upd_taken) ||
            (u_mode == BMODE_NEVER  &&  upd_taken))
          mode_q[u_set][u_way] <= BMODE_DYN;
        if (upd_taken)
          tgt_q[u_set][u_way] <= upd_target;
      end else begin
        vld_q[u_set][u_way]  <= 1'b1;
        tag_q[u_set][u_way]  <= u_tag;
        tgt_q[u_set][u_way]  <= upd_target;
        mode_q[u_set][u_way] <= upd_taken ? BMODE_ALWAYS : BMODE_NEVER;
      end
    end
  end

endmodule

// File: rtl/dual_thread_bpred.sv
module dual_thread_bpred
  import bpred_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int THREADS   = 2,
  parameter int HIST_W    = 12,
  parameter int PHT_IDX_W = 13,
  parameter int SETS      = 32,
  parameter int WAYS      = 4,
  localparam int TID_W    = $clog2(THREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [TID_W-1:0] lk_tid,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic             rsp_taken,
  output logic [PC_W-1:0]  rsp_target,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [TID_W-1:0] upd_tid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_kind,
  input  logic             upd_taken,
  input  logic [PC_W-1:0]  upd_target
);

  logic [THREADS-1:0][HIST_W-1:0] hist_vec;
  logic                 lk_fire, upd_cond;
  logic [PHT_IDX_W-1:0] lk_idx, upd_idx;
  logic [1:0]           lk_ctr;
  logic                 btb_hit;
  bmode_e               btb_mode;
  logic [PC_W-1:0]      btb_target;
  logic                 pred_taken;
  logic                 unused_pc_lsbs;

  assign unused_pc_lsbs = ^{lk_pc[1:0], upd_pc[1:0]};

  assign upd_ready = 1'b1;
  assign lk_ready  = !rsp_valid || rsp_ready;
  assign lk_fire   = lk_valid && lk_ready;
  assign upd_cond  = upd_valid && !upd_kind;

  assign lk_idx  = PHT_IDX_W'(hist_vec[lk_tid])  ^ lk_pc[PHT_IDX_W+1:2];
  assign upd_idx = PHT_IDX_W'(hist_vec[upd_tid]) ^ upd_pc[PHT_IDX_W+1:2];

  bpred_history #(.THREADS(THREADS), .HIST_W(HIST_W), .TID_W(TID_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(upd_cond), .shift_tid(upd_tid), .shift_bit(upd_taken),
    .hist(hist_vec)
  );

  bpred_pht #(.IDX_W(PHT_IDX_W)) u_pht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_ctr(lk_ctr),
    .wr_en(upd_cond), .wr_idx(upd_idx), .wr_taken(upd_taken)
  );

  bpred_btb #(.PC_W(PC_W), .SETS(SETS), .WAYS(WAYS)) u_btb (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hit(btb_hit), .lk_mode(btb_mode), .lk_target(btb_target),
    .upd_en(upd_cond), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
  );

  always_comb begin
    unique case (btb_mode)
      BMODE_ALWAYS: pred_taken = 1'b1;
      BMODE_NEVER:  pred_taken = 1'b0;
      default:      pred_taken = lk_ctr[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_taken  <= 1'b0;
      rsp_target <= '0;
    end else if (lk_fire) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= btb_hit;
      rsp_taken  <= btb_hit && pred_taken;
      rsp_target <= btb_hit ? btb_target : '0;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/bpred_checker.sv
module bpred_checker #(
  parameter int PC_W    = 32,
  parameter int THREADS = 2,
  parameter int HIST_W  = 12,
  parameter int TID_W   = 1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           lk_valid,
  input logic                           lk_ready,
  input logic                           rsp_valid,
  input logic                           rsp_ready,
  input logic                           rsp_hit,
  input logic                           rsp_taken,
  input logic [PC_W-1:0]                rsp_target,
  input logic                           upd_valid,
  input logic [TID_W-1:0]               upd_tid,
  input logic                           upd_kind,
  input logic                           upd_taken,
  input logic [THREADS-1:0][HIST_W-1:0] hist_vec
);

  // R2: an accepted lookup yields a response on the next cycle
  p_accept_gives_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);

  // R2: a stalled response stays frozen
  p_hold_stalled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) &&
                                   $stable(rsp_taken) && $stable(rsp_target)));

  // R2: a response only appears after an accepted request
  p_rsp_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(lk_valid && lk_ready));

  // R3: a miss carries no direction and no target
  p_miss_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_taken && rsp_target == '0));

  // R7: a conditional update shifts its outcome into its thread's history
  p_hist_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_kind) |=>
      hist_vec[$past(upd_tid)] == {$past(hist_vec[upd_tid][HIST_W-2:0]), $past(upd_taken)});

  // R8: jumps leave every history alone
  p_jump_keeps_hist_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_kind) |=> $stable(hist_vec));

endmodule

bind dual_thread_bpred bpred_checker #(
  .PC_W(PC_W), .THREADS(THREADS), .HIST_W(HIST_W), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_hit(rsp_hit), .rsp_taken(rsp_taken), .rsp_target(rsp_target),
  .upd_valid(upd_valid), .upd_tid(upd_tid), .upd_kind(upd_kind),
  .upd_taken(upd_taken), .hist_vec(hist_vec)
);

// File: tb/dual_thread_bpred_test.sv
module dual_thread_bpred_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic        is_upd;
    logic        tid;
    logic [31:0] pc;
    logic        kind;
    logic        taken;
    logic [31:0] target;
    logic        e_hit;
    logic        e_taken;
    logic [31:0] e_target;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 11;
  // A=0x1000 set0, B=0x1104 set1, C=0x1208 set2
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 32'h1000, 1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0,    8'd3},  // R3 miss
    '{1'b1, 1'b0, 32'h1000, 1'b0, 1'b1, 32'h2000, 1'b0, 1'b0, 32'h0,    8'd4},  // R4 install taken
    '{1'b0, 1'b0, 32'h1000, 1'b0, 1'b0, 32'h0,    1'b1, 1'b1, 32'h2000, 8'd5},  // R5 tag beats ctr 01
    '{1'b1, 1'b0, 32'h1000, 1'b0, 1'b0, 32'h9999, 1'b0, 1'b0, 32'h0,    8'd6},  // R6 flip to dynamic
    '{1'b0, 1'b0, 32'h1000, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 32'h2000, 8'd6},  // R6 ctr 01, old target
    '{1'b0, 1'b1, 32'h1000, 1'b0, 1'b0, 32'h0,    1'b1, 1'b1, 32'h2000, 8'd7},  // R7 shared ctr 10
    '{1'b1, 1'b1, 32'h1104, 1'b0, 1'b0, 32'h3000, 1'b0, 1'b0, 32'h0,    8'd4},  // R4 install not-taken
    '{1'b0, 1'b1, 32'h1104, 1'b0, 1'b0, 32'h0,    1'b1, 1'b0, 32'h3000, 8'd4},  // R4 never tag
    '{1'b1, 1'b1, 32'h1208, 1'b1, 1'b1, 32'h4000, 1'b0, 1'b0, 32'h0,    8'd8},  // R8 jump
    '{1'b0, 1'b1, 32'h1208, 1'b0, 1'b0, 32'h0,    1'b0, 1'b0, 32'h0,    8'd8},  // R8 no install
    '{1'b0, 1'b1, 32'h1000, 1'b0, 1'b0, 32'h0,    1'b1, 1'b1, 32'h2000, 8'd8}   // R8 history intact
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_ready, lk_tid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_hit, rsp_taken;
  logic [31:0] rsp_target;
  logic        upd_valid = 1'b0, upd_ready, upd_tid = 1'b0, upd_kind = 1'b0, upd_taken = 1'b0;
  logic [31:0] upd_pc = '0, upd_target = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_thread_bpred uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_tid(lk_tid), .lk_pc(lk_pc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_taken(rsp_taken), .rsp_target(rsp_target),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_tid(upd_tid), .upd_pc(upd_pc),
    .upd_kind(upd_kind), .upd_taken(upd_taken), .upd_target(upd_target)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_rsp(input string req, input logic h, input logic t, input logic [31:0] g);
    check(req, {rsp_valid, rsp_hit, rsp_taken, rsp_target}, {1'b1, h, t, g});
  endtask

  task automatic lookup(input logic tid, input logic [31:0] pc);
    @(negedge clk);
    lk_valid = 1'b1; lk_tid = tid; lk_pc = pc;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic update(input logic tid, input logic [31:0] pc, input logic kind,
                        input logic tk, input logic [31:0] tg);
    @(negedge clk);
    upd_valid = 1'b1; upd_tid = tid; upd_pc = pc; upd_kind = kind;
    upd_taken = tk; upd_target = tg;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 rsp_valid after reset", rsp_valid, 0);
    check("R1 lk_ready after reset", lk_ready, 1);
    check("R11 upd_ready", upd_ready, 1);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      if (VECS[i].is_upd) begin
        update(VECS[i].tid, VECS[i].pc, VECS[i].kind, VECS[i].taken, VECS[i].target);
        check({tag, " upd_ready"}, upd_ready, 1);
      end else begin
        lookup(VECS[i].tid, VECS[i].pc);
        check_rsp(tag, VECS[i].e_hit, VECS[i].e_taken, VECS[i].e_target);
      end
    end

    // R9: lookup and install of D in the same cycle
    @(negedge clk);
    lk_valid = 1'b1; lk_tid = 1'b0; lk_pc = 32'h1310;
    upd_valid = 1'b1; upd_tid = 1'b0; upd_pc = 32'h1310; upd_kind = 1'b0;
    upd_taken = 1'b1; upd_target = 32'h5000;
    @(negedge clk);
    lk_valid = 1'b0; upd_valid = 1'b0;
    check_rsp("R9 same-cycle sees old", 1'b0, 1'b0, 32'h0);
    lookup(1'b0, 32'h1310);
    check_rsp("R9 later sees new", 1'b1, 1'b1, 32'h5000);

    // R2: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; lk_valid = 1'b1; lk_tid = 1'b1; lk_pc = 32'h1000;
    @(negedge clk);
    check("R2 stall blocks lk_ready", lk_ready, 0);
    lk_pc = 32'h1104;
    @(negedge clk);
    check_rsp("R2 held response", 1'b1, 1'b1, 32'h2000);
    rsp_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    check_rsp("R2 next request after drain", 1'b1, 1'b0, 32'h3000);
    @(negedge clk);
    check("R2 response drained", rsp_valid, 0);

    // R10: fill set 5, refresh way0, install a fifth branch
    for (int k = 0; k < 4; k++)
      update(1'b0, 32'h8014 + 32'(k) * 32'h80, 1'b0, 1'b1, 32'hA000 + 32'(k) * 32'h10);
    update(1'b0, 32'h8014, 1'b0, 1'b1, 32'hA000);
    update(1'b0, 32'h8214, 1'b0, 1'b1, 32'hA040);
    lookup(1'b0, 32'h8114);
    check_rsp("R10 pseudo-LRU victim evicted", 1'b0, 1'b0, 32'h0);
    lookup(1'b0, 32'h8014);
    check_rsp("R10 refreshed way kept", 1'b1, 1'b1, 32'hA000);
    lookup(1'b0, 32'h8094);
    check_rsp("R10 other way kept", 1'b1, 1'b1, 32'hA010);
    lookup(1'b0, 32'h8214);
    check_rsp("R10 new entry present", 1'b1, 1'b1, 32'hA040);

    // R1: a reset mid-run empties the target cache
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 rsp_valid cleared", rsp_valid, 0);
    lookup(1'b0, 32'h1000);
    check_rsp("R1 entries gone", 1'b0, 1'b0, 32'h0);

    finish_run();
  end

endmodule